// File: doc/BRIEF.md
# Streaming Bayer Demosaic Unit

This block turns a raw single-channel pixel stream from a colour sensor behind a 2x2 mosaic filter into a full RGB stream, one RGB pixel for each raw pixel. Each output pixel is reconstructed from a 2x2 window of raw samples. The window spans the current row and the row above it, and the current column and the column to its left. The row above comes from a single line buffer, so no frame is ever stored and the latency stays within a fraction of a line.

Both the raw input and the RGB output are valid/ready streams carrying a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of each line. These flags are the only source of row and column position, and the mosaic phase is picked by a 2-bit static configuration input. Back-pressure rules: a beat transfers on a clock edge where valid and ready are both high. An output beat held with `m_ready` low stays unchanged until it is taken. `s_ready` follows `m_ready` combinationally, so a stall at the output stops the input in the same cycle. Once in each line the block also drops `s_ready` for one cycle while it emits column 0.

Top module: `bayer_demosaic`

## Requirements
- R1: After reset `m_valid` is low and `s_ready` is high.
- R2: Every accepted raw pixel yields exactly one RGB pixel, in input order. The pixel in column 0 is emitted only once the column-1 pixel is present. Every other pixel appears on the output in the cycle after it is accepted, provided the output is not stalled.
- R3: `cfa_phase` places the red site at row parity `cfa_phase[1]` and column parity `cfa_phase[0]`, with row and column counted from 0. Blue sits at the opposite parities and green at the two mixed parities. The encodings are 0 = RGGB, 1 = GRBG, 2 = GBRG and 3 = BGGR.
- R4: The window for row r, column c uses columns c-1 and c. For column 0 it uses columns 0 and 1.
- R5: Red and blue are copied from the single red and blue sites in the window. Green is the floor of the mean of the two green sites.
- R6: On the first row of a frame the current row's samples stand in for the missing row above. They are treated as if they sat at that row's parity.
- R7: `m_sof` and `m_eol` appear on exactly the output pixels whose inputs carried `s_sof` and `s_eol`.
- R8: While `m_valid` is high and `m_ready` is low, `m_rgb`, `m_sof` and `m_eol` hold, `m_valid` stays high and `s_ready` is low. No pixel is dropped or duplicated.
- R9: `s_sof` restarts the count at row 0, column 0. `s_eol` ends the line and flips the row parity. Lines are 2 to MAX_COLS pixels wide.
- R10: While the column-1 pixel waits on the input and column 0 is being sent, `s_ready` is low for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfa_phase | input | 2 | Mosaic phase select (R3 encoding) |
| s_valid | input | 1 | Raw stream valid |
| s_ready | output | 1 | Raw stream ready |
| s_raw | input | PIX_W | Raw sample |
| s_sof | input | 1 | First pixel of a frame |
| s_eol | input | 1 | Last pixel of a line |
| m_valid | output | 1 | RGB stream valid |
| m_ready | input | 1 | RGB stream ready |
| m_rgb | output | 3*PIX_W | Red in the top third, green in the middle, blue in the bottom third |
| m_sof | output | 1 | Start-of-frame flag, aligned to its pixel |
| m_eol | output | 1 | End-of-line flag, aligned to its pixel |

## Verification
The assertions check the handshake on every cycle. A stalled output must hold its payload and block the input, an output may only rise after an input beat was offered, and a single output beat never carries both frame-start and line-end flags. The colour values themselves are covered only by the bench scenarios: the four phases, the first-row substitution, the column-0 look-ahead, odd line widths, and traffic with gaps and stalls. In each scenario the bench compares every output against a model built from frame coordinates. The one-cycle column-0 bubble and the exact output cycles are shown by a directed timing scenario.

// File: rtl/demosaic_pkg.sv
package demosaic_pkg;
  // Position of the red site inside the 2x2 cell: {row parity, column parity}
  typedef enum logic [1:0] {
    PH_RGGB = 2'd0,
    PH_GRBG = 2'd1,
    PH_GBRG = 2'd2,
    PH_BGGR = 2'd3
  } cfa_phase_e;
endpackage

// File: rtl/demosaic_pos_track.sv
module demosaic_pos_track #(
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic             adv,
  output logic [COL_W-1:0] col,
  output logic             row_par,
  output logic             first_row
);
  logic [COL_W-1:0] col_q;
  logic             row_q;
  logic             first_q;

  // Start of frame overrides the stored position for the current beat
  always_comb begin
    col       = in_sof ? '0   : col_q;
    row_par   = in_sof ? 1'b0 : row_q;
    first_row = in_sof ? 1'b1 : first_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= 1'b0;
      first_q <= 1'b1;
    end else if (adv) begin
      if (in_eol) begin
        col_q   <= '0;
        row_q   <= ~row_par;
        first_q <= 1'b0;
      end else begin
        col_q   <= col + COL_W'(1);
        row_q   <= row_par;
        first_q <= first_row;
      end
    end
  end
endmodule

// File: rtl/demosaic_line_mem.sv
module demosaic_line_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // Read returns the previous line's sample before this beat overwrites it
  assign rd_data = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end
endmodule

// File: rtl/demosaic_interp.sv
module demosaic_interp
  import demosaic_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  cfa_phase_e         phase,
  input  logic               row_par,
  input  logic               left_par,
  input  logic [PIX_W-1:0]   up_l,
  input  logic [PIX_W-1:0]   up_r,
  input  logic [PIX_W-1:0]   cur_l,
  input  logic [PIX_W-1:0]   cur_r,
  output logic [3*PIX_W-1:0] rgb
);
  logic             red_in_cur;
  logic             red_in_left;
  logic [PIX_W-1:0] red_v, blue_v, g_a, g_b;
  logic [PIX_W:0]   g_sum;

  // The up row always has the opposite row parity of the current row
  assign red_in_cur  = (phase[1] == row_par);
  assign red_in_left = (phase[0] == left_par);

  always_comb begin
    if (red_in_cur) begin
      red_v  = red_in_left ? cur_l : cur_r;
      blue_v = red_in_left ? up_r  : up_l;
      g_a    = red_in_left ? cur_r : cur_l;
      g_b    = red_in_left ? up_l  : up_r;
    end else begin
      red_v  = red_in_left ? up_l  : up_r;
      blue_v = red_in_left ? cur_r : cur_l;
      g_a    = red_in_left ? up_r  : up_l;
      g_b    = red_in_left ? cur_l : cur_r;
    end
    g_sum = {1'b0, g_a} + {1'b0, g_b};
    rgb   = {red_v, g_sum[PIX_W:1], blue_v};
  end
endmodule

// File: rtl/bayer_demosaic.sv
module bayer_demosaic
  import demosaic_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int MAX_COLS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfa_phase,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [PIX_W-1:0]   s_raw,
  input  logic               s_sof,
  input  logic               s_eol,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [3*PIX_W-1:0] m_rgb,
  output logic               m_sof,
  output logic               m_eol
);
  localparam int COL_W = $clog2(MAX_COLS);
  localparam int RGB_W = 3 * PIX_W;

  logic [COL_W-1:0] col_eff;
  logic             row_eff, first_eff;
  logic             load_ok, col1_wait, emit_left, accept, at_col0;
  logic             col0_sent, held_sof;
  logic [PIX_W-1:0] lb_rd, up_val, cur_l, up_l;
  logic [RGB_W-1:0] pix_rgb;
  cfa_phase_e       phase;

  assign phase = cfa_phase_e'(cfa_phase);

  demosaic_pos_track #(.COL_W(COL_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_sof    (s_sof),
    .in_eol    (s_eol),
    .adv       (accept),
    .col       (col_eff),
    .row_par   (row_eff),
    .first_row (first_eff)
  );

  // Handshake: column 0 is emitted while column 1 waits on the input
  assign at_col0   = (col_eff == '0);
  assign col1_wait = (col_eff == COL_W'(1)) && !col0_sent;
  assign load_ok   = !m_valid || m_ready;
  assign s_ready   = load_ok && !col1_wait;
  assign accept    = s_valid && s_ready;
  assign emit_left = s_valid && load_ok && col1_wait;

  demosaic_line_mem #(.DEPTH(MAX_COLS), .DW(PIX_W)) u_line (
    .clk     (clk),
    .wr_en   (accept),
    .addr    (col_eff),
    .wr_data (s_raw),
    .rd_data (lb_rd)
  );

  // First row of a frame: current row stands in for the missing one
  assign up_val = first_eff ? s_raw : lb_rd;

  demosaic_interp #(.PIX_W(PIX_W)) u_interp (
    .phase    (phase),
    .row_par  (row_eff),
    .left_par (~col_eff[0]),
    .up_l     (up_l),
    .up_r     (up_val),
    .cur_l    (cur_l),
    .cur_r    (s_raw),
    .rgb      (pix_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid   <= 1'b0;
      m_rgb     <= '0;
      m_sof     <= 1'b0;
      m_eol     <= 1'b0;
      cur_l     <= '0;
      up_l      <= '0;
      held_sof  <= 1'b0;
      col0_sent <= 1'b0;
    end else begin
      if (load_ok) begin
        m_valid <= emit_left || (accept && !at_col0);
        if (emit_left) begin
          m_rgb <= pix_rgb;
          m_sof <= held_sof;
          m_eol <= 1'b0;
        end else if (accept && !at_col0) begin
          m_rgb <= pix_rgb;
          m_sof <= s_sof;
          m_eol <= s_eol;
        end
      end
      if (emit_left) col0_sent <= 1'b1;
      if (accept) begin
        cur_l     <= s_raw;
        up_l      <= up_val;
        col0_sent <= 1'b0;
        if (at_col0) held_sof <= s_sof;
      end
    end
  end
endmodule

// File: rtl/bayer_demosaic_chk.sv
module bayer_demosaic_chk #(
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic               m_valid,
  input logic               m_ready,
  input logic [3*PIX_W-1:0] m_rgb,
  input logic               m_sof,
  input logic               m_eol
);
  // R8: a stalled output beat keeps its payload
  a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_rgb) && $stable(m_sof) && $stable(m_eol)));

  // R8: a stalled output blocks the input
  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R2: a new output only follows an offered input beat
  a_r2_out_after_in: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid));

  // R7: with lines of two or more pixels, no beat is both frame start and line end
  a_r7_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(m_sof && m_eol));
endmodule

bind bayer_demosaic bayer_demosaic_chk #(.PIX_W(PIX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_rgb   (m_rgb),
  .m_sof   (m_sof),
  .m_eol   (m_eol)
);

// File: tb/bayer_demosaic_tb.sv
`timescale 1ns/1ps
module bayer_demosaic_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfa_phase = 2'd0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0;
  logic [7:0]  s_raw = '0;
  logic        s_ready;
  logic        m_valid, m_sof, m_eol;
  logic        m_ready = 1'b1;
  logic [23:0] m_rgb;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] img [64];

  always #2.5 clk = ~clk;

  bayer_demosaic u_dut (
    .clk(clk), .rst_n(rst_n), .cfa_phase(cfa_phase),
    .s_valid(s_valid), .s_ready(s_ready), .s_raw(s_raw), .s_sof(s_sof), .s_eol(s_eol),
    .m_valid(m_valid), .m_ready(m_ready), .m_rgb(m_rgb), .m_sof(m_sof), .m_eol(m_eol)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Independent model: classify each window site by absolute parities
  function automatic logic [23:0] model(input logic [1:0] ph, input int w, input int r, input int c);
    int rows [2], rpar [2], cols [2];
    int rv = 0, bv = 0, gs = 0;
    rows[0] = (r == 0) ? r : r - 1;
    rpar[0] = (r + 1) % 2;
    rows[1] = r;
    rpar[1] = r % 2;
    cols[0] = (c == 0) ? 0 : c - 1;
    cols[1] = (c == 0) ? 1 : c;
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 2; x++) begin
        int v  = int'(img[rows[y] * w + cols[x]]);
        int px = cols[x] % 2;
        if (rpar[y] == int'(ph[1]) && px == int'(ph[0]))      rv = v;
        else if (rpar[y] != int'(ph[1]) && px != int'(ph[0])) bv = v;
        else                                                  gs += v;
      end
    return {rv[7:0], 8'(gs / 2), bv[7:0]};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset
    chk(m_valid == 1'b0, "R1", "m_valid after reset", 32'(m_valid), 32'd0);
    chk(s_ready == 1'b1, "R1", "s_ready after reset", 32'(s_ready), 32'd1);
  endtask

  // R2 and R10: exact cycles around the column-0 look-ahead
  task automatic t_timing();
    cfa_phase = 2'd0;
    m_ready   = 1'b1;
    @(negedge clk);
    s_valid = 1'b1; s_raw = 8'd10; s_sof = 1'b1; s_eol = 1'b0;
    #1;
    chk(s_ready == 1'b1, "R2", "col0 accepted", 32'(s_ready), 32'd1);
    @(negedge clk);
    s_raw = 8'd20; s_sof = 1'b0;
    #1;
    chk(m_valid == 1'b0, "R2", "col0 held until col1", 32'(m_valid), 32'd0);
    chk(s_ready == 1'b0, "R10", "bubble while col0 sent", 32'(s_ready), 32'd0);
    @(negedge clk);
    #1;
    chk(m_valid && m_sof, "R7", "col0 out with sof", {m_valid, m_sof}, 32'd3);
    // R6/R5: row 0 RGGB: red 10, green (20+10)/2, blue replicated 20
    chk(m_rgb == 24'h0A0F14, "R6", "first-row col0 rgb", m_rgb, 24'h0A0F14);
    chk(s_ready == 1'b1, "R10", "col1 accepted after bubble", 32'(s_ready), 32'd1);
    @(negedge clk);
    s_valid = 1'b0;
    #1;
    chk(m_valid && !m_sof, "R2", "col1 one cycle after accept", {m_valid, m_sof}, 32'd2);
    @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R2", "no extra output", 32'(m_valid), 32'd0);
  endtask

  // R3 R4 R5 R6 R7 R8 R9: full frame with optional gaps and stalls
  task automatic run_frame(input logic [1:0] ph, input int w, input int h, input int seed,
                           input bit stalls, input bit gaps);
    int n = w * h, pi = 0, po = 0, t = 0;
    bit held = 1'b0;
    logic [23:0] hold_rgb;
    for (int i = 0; i < n; i++) begin
      int r = i / w, c = i % w;
      img[i] = 8'((r * 53 + c * 29 + seed * 17 + r * c * 7) & 255);
    end
    cfa_phase = ph;
    while (po < n && t < 4000) begin
      @(negedge clk);
      t++;
      s_valid = (pi < n) && !(gaps && (t % 4 == 2));
      s_raw   = img[pi < n ? pi : 0];
      s_sof   = (pi == 0);
      s_eol   = (pi % w == w - 1);
      m_ready = !(stalls && (t % 3 == 1));
      #1;
      if (held)
        chk(m_valid && m_rgb == hold_rgb, "R8", "stalled beat holds", m_rgb, hold_rgb);
      held = 1'b0;
      if (m_valid && !m_ready) begin
        chk(s_ready == 1'b0, "R8", "input blocked on stall", 32'(s_ready), 32'd0);
        held = 1'b1;
        hold_rgb = m_rgb;
      end
      if (m_valid && m_ready) begin
        int r = po / w, c = po % w;
        logic [23:0] e = model(ph, w, r, c);
        string tg = (r == 0) ? "R6" : ((c == 0) ? "R4" : "R5");
        chk(m_rgb == e, tg, $sformatf("R3 phase %0d pixel r%0d c%0d", ph, r, c), m_rgb, e);
        chk(m_sof == (po == 0) && m_eol == (c == w - 1), "R7",
            $sformatf("flags r%0d c%0d", r, c), {m_sof, m_eol}, {(po == 0), (c == w - 1)});
        po++;
      end
      if (s_valid && s_ready) pi++;
    end
    chk(po == n, "R9", "output count", 32'(po), 32'(n));
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0; m_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R2", "no extra pixel after frame", 32'(m_valid), 32'd0);
  endtask

  initial begin
    do_reset();
    t_timing();
    run_frame(2'd0, 6, 4, 1, 1'b0, 1'b0);
    run_frame(2'd1, 5, 3, 2, 1'b1, 1'b0);
    run_frame(2'd2, 4, 4, 3, 1'b1, 1'b1);
    run_frame(2'd3, 6, 3, 4, 1'b0, 1'b1);
    run_frame(2'd3, 3, 5, 5, 1'b1, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule